// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block sends one command at a time on the SD card command line and collects the card's reply. Software first writes a 32-bit argument and then a 16-bit command word. The command word write launches the command. The engine builds a 48-bit frame that carries its own CRC7 and shifts it out. It then waits for the card's reply, which is either a short 48-bit reply or a long 136-bit reply. The engine checks the reply, stores it in four 32-bit result registers and reports the outcome as single-cycle event pulses.

The engine also drives two inhibit flags. `inhibit_cmd` covers the command line for the whole life of a command. `inhibit_dat` covers commands that tell the card to hold DAT0 low while it is busy. This flag stays high after the reply until DAT0 is seen high again. A write that conflicts with an inhibit flag is dropped. Bit timing comes from `sd_stb`, which is a one-cycle strobe per SD bit period, aligned with the falling SD clock. Outgoing bits change on the strobe, and incoming bits are sampled on it.

The controller has five states:
- IDLE goes to SEND when a command word is accepted.
- SEND goes to EVAL after the 48th bit when no reply is expected. Otherwise it goes to WAIT.
- WAIT goes to RECV when it samples a low start bit. It goes back to IDLE on a reply timeout.
- RECV goes to EVAL on the last reply bit.
- EVAL always goes back to IDLE after one cycle. In that cycle it runs the checks, loads the result registers and queues the event pulses.

Top module: `sdc_cmd_engine`

## Requirements
- R1: Each accepted command is sent as 48 bits, MSB first, one bit per `sd_stb`. The bits are, in order: a 0, a 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, initial value zero, computed over the first 40 bits) and a closing 1. `cmd_oe` is high for exactly those 48 bit periods, and `cmd_out` rests at 1 outside them.
- R2: The command word fields are:
  - bits 13:8: the command index.
  - bit 4: enables the index check.
  - bit 3: enables the CRC check.
  - bits 1:0: the reply kind, where 00 is none, 01 is 136-bit, 10 is 48-bit and 11 is 48-bit followed by a busy wait.
- R3: `inhibit_cmd` rises in the cycle after a command word is accepted and falls in the same cycle as that command's event pulse. A command word written while `inhibit_cmd` is high is ignored: no second frame is sent and no second event follows.
- R4: A command with reply kind 00 produces `evt_done` with no error right after its frame.
- R5: A 48-bit reply puts its bits 39:8 (the 32-bit card status) into `resp0`.
- R6: A 136-bit reply is stored without its CRC byte:
  - `resp3` receives {8'h00, bits 127:104}.
  - `resp2` receives bits 103:72.
  - `resp1` receives bits 71:40.
  - `resp0` receives bits 39:8.
- R7: When the CRC check is enabled and the reply's bits 7:1 differ from the CRC7 of the reply, both `err_crc` and `evt_error` pulse together with `evt_done`. The CRC is taken over bits 47:8 of a 48-bit reply and over bits 127:8 of a 136-bit reply. With the check disabled, a bad CRC raises no error.
- R8: When the index check is enabled on a 48-bit reply and the reply's bits 45:40 differ from the command index, `err_index` and `evt_error` pulse. With the check disabled, a wrong index raises no error.
- R9: A reply whose last bit is 0 pulses `err_endbit` and `evt_error`.
- R10: Reply timeout is judged on the `sd_stb` samples taken after the frame.
  - If the first 64 samples are all high, `err_timeout` and `evt_error` pulse without `evt_done`, and the engine returns to IDLE.
  - A start bit on the 64th sample is still accepted.
- R11: The busy wait works as follows:
  - Accepting a reply-kind-11 command raises `inhibit_dat`.
  - `inhibit_dat` stays high after that command's `evt_done` until DAT0 is sampled high on `sd_stb`.
  - A reply-kind-11 command word is ignored while `inhibit_dat` is high. Other kinds are still accepted.
  - A reply timeout on a busy command clears `inhibit_dat`.
- R12: Every event output is a single-cycle pulse.
- R13: After reset, both inhibit flags are low, `cmd_oe` is low, `cmd_out` is high and all result registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_stb | input | 1 | One pulse per SD bit period (falling SD clock) |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command word write strobe; launches the command |
| cmd_wdata | input | 16 | Command word write data |
| cmd_in | input | 1 | Sampled level of the command line |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| dat0_in | input | 1 | Sampled level of DAT0 |
| inhibit_cmd | output | 1 | A command is in flight |
| inhibit_dat | output | 1 | A busy-wait command has not released DAT0 |
| resp0 | output | 32 | Result register 0 |
| resp1 | output | 32 | Result register 1 |
| resp2 | output | 32 | Result register 2 |
| resp3 | output | 32 | Result register 3 |
| evt_done | output | 1 | Command-complete pulse |
| evt_error | output | 1 | Error summary pulse |
| err_timeout | output | 1 | No reply start bit in time |
| err_crc | output | 1 | Reply CRC mismatch |
| err_index | output | 1 | Reply index mismatch |
| err_endbit | output | 1 | Reply end bit was 0 |

## Verification
The bound checker watches properties that hold on every cycle:
- Frames start with a low bit and are only driven while `inhibit_cmd` is high.
- Every cause flag comes with the summary pulse.
- A timeout never comes with `evt_done`.
- Pulses last one cycle.
- `inhibit_cmd` is low whenever an event fires.
- `inhibit_dat` only rises as a command is launched.

Some behaviour depends on what the card sends, so only the bench scenarios can show it:
- exact frame contents and CRC values;
- the layout of the result registers;
- the 63/64 sample timeout boundary;
- dropped writes;
- the order of the busy release.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_RECV,
        S_EVAL
    } cmd_state_t;

    localparam logic [1:0] RT_NONE  = 2'b00;
    localparam logic [1:0] RT_LONG  = 2'b01;
    localparam logic [1:0] RT_SHORT = 2'b10;
    localparam logic [1:0] RT_BUSY  = 2'b11;

    localparam int CRC_IN_W = 120;

    // Serial CRC7 over a zero-extended field; leading zeros leave a zero state untouched.
    function automatic logic [6:0] crc7_calc(input logic [CRC_IN_W-1:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = CRC_IN_W - 1; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
    parameter int IDX_W   = 6,
    parameter int ARG_W   = 32,
    parameter int FRAME_W = 2 + IDX_W + ARG_W + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    input  logic             shift,
    output logic             bit_o,
    output logic             last_o
);
    localparam int CNT_W  = $clog2(FRAME_W);
    localparam int HEAD_W = 2 + IDX_W + ARG_W;

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;
    logic [HEAD_W-1:0]  head;

    assign head = {2'b01, idx, arg};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '1;
            cnt <= '0;
        end else if (load) begin
            sr  <= {head, sdc_pkg::crc7_calc(sdc_pkg::CRC_IN_W'(head)), 1'b1};
            cnt <= '0;
        end else if (shift) begin
            sr  <= {sr[FRAME_W-2:0], 1'b1};
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_o  = sr[FRAME_W-1];
    assign last_o = (cnt == CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx #(
    parameter int SHORT_W = 48,
    parameter int LONG_W  = 136
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_i,
    input  logic              long_sel,
    output logic [LONG_W-1:0] sr_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_o <= '0;
            cnt  <= '0;
        end else if (clear) begin
            sr_o <= '0;
            cnt  <= '0;
        end else if (sample) begin
            sr_o <= {sr_o[LONG_W-2:0], bit_i};
            cnt  <= cnt + 1'b1;
        end
    end

    // High when the bit about to be sampled completes the reply
    assign last_o = long_sel ? (cnt == CNT_W'(LONG_W - 1)) : (cnt == CNT_W'(SHORT_W - 1));
endmodule

// File: rtl/sdc_busy_track.sv
module sdc_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic abort_i,
    input  logic stb_i,
    input  logic dat0_i,
    output logic busy_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            armed  <= 1'b0;
        end else if (set_i) begin
            busy_o <= 1'b1;
            armed  <= 1'b0;
        end else if (abort_i) begin
            busy_o <= 1'b0;
            armed  <= 1'b0;
        end else if (arm_i) begin
            armed  <= 1'b1;
        end else if (armed && stb_i && dat0_i) begin
            busy_o <= 1'b0;
            armed  <= 1'b0;
        end
    end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int ARG_W       = 32,
    parameter int CMDR_W      = 16,
    parameter int IDX_W       = 6,
    parameter int RSP_TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_stb,
    input  logic              arg_we,
    input  logic [ARG_W-1:0]  arg_wdata,
    input  logic              cmd_we,
    input  logic [CMDR_W-1:0] cmd_wdata,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              dat0_in,
    output logic              inhibit_cmd,
    output logic              inhibit_dat,
    output logic [31:0]       resp0,
    output logic [31:0]       resp1,
    output logic [31:0]       resp2,
    output logic [31:0]       resp3,
    output logic              evt_done,
    output logic              evt_error,
    output logic              err_timeout,
    output logic              err_crc,
    output logic              err_index,
    output logic              err_endbit
);
    localparam int WCNT_W  = $clog2(RSP_TIMEOUT);
    localparam int SHORT_W = 48;
    localparam int LONG_W  = 136;

    cmd_state_t state, state_nx;

    logic [ARG_W-1:0]  arg_q, arg_eff;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        rtype_q;
    logic              crc_en_q, idx_en_q;
    logic [WCNT_W-1:0] wcnt;

    // command word fields
    logic [IDX_W-1:0] w_idx;
    logic [1:0]       w_rtype;
    logic             w_idx_chk, w_crc_chk;
    logic             unused_bits;
    assign w_idx     = cmd_wdata[8 +: IDX_W];
    assign w_idx_chk = cmd_wdata[4];
    assign w_crc_chk = cmd_wdata[3];
    assign w_rtype   = cmd_wdata[1:0];

    logic accept, tx_bit, tx_last, rx_last, rx_sample, timeout_hit;
    logic [LONG_W-1:0] rx_sr;
    assign unused_bits = ^{cmd_wdata[CMDR_W-1:8+IDX_W], cmd_wdata[7:5], cmd_wdata[2], rx_sr[LONG_W-1:128]};

    assign accept  = cmd_we && (state == S_IDLE) && !(w_rtype == RT_BUSY && inhibit_dat);
    assign arg_eff = arg_we ? arg_wdata : arg_q;

    sdc_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(accept), .idx(w_idx), .arg(arg_eff),
        .shift(sd_stb && state == S_SEND), .bit_o(tx_bit), .last_o(tx_last)
    );

    assign rx_sample = sd_stb && ((state == S_WAIT && !cmd_in) || state == S_RECV);

    sdc_rsp_rx #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(accept), .sample(rx_sample), .bit_i(cmd_in),
        .long_sel(rtype_q == RT_LONG), .sr_o(rx_sr), .last_o(rx_last)
    );

    assign timeout_hit = (state == S_WAIT) && sd_stb && cmd_in && (wcnt == WCNT_W'(RSP_TIMEOUT - 1));

    sdc_busy_track u_busy (
        .clk(clk), .rst_n(rst_n),
        .set_i(accept && w_rtype == RT_BUSY),
        .arm_i(state == S_EVAL && rtype_q == RT_BUSY),
        .abort_i(timeout_hit && rtype_q == RT_BUSY),
        .stb_i(sd_stb), .dat0_i(dat0_in), .busy_o(inhibit_dat)
    );

    // reply checks
    logic       is_long, has_rsp, crc_bad, idx_bad, end_bad;
    logic [6:0] crc_calc;
    assign is_long  = (rtype_q == RT_LONG);
    assign has_rsp  = (rtype_q != RT_NONE);
    assign crc_calc = is_long ? crc7_calc(rx_sr[127:8]) : crc7_calc(CRC_IN_W'(rx_sr[SHORT_W-1:8]));
    assign crc_bad  = has_rsp && crc_en_q && (crc_calc != rx_sr[7:1]);
    assign idx_bad  = has_rsp && !is_long && idx_en_q && (rx_sr[45:40] != idx_q);
    assign end_bad  = has_rsp && !rx_sr[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_SEND;
            S_SEND: if (sd_stb && tx_last) state_nx = (rtype_q == RT_NONE) ? S_EVAL : S_WAIT;
            S_WAIT: begin
                if (sd_stb && !cmd_in) state_nx = S_RECV;
                else if (timeout_hit)  state_nx = S_IDLE;
            end
            S_RECV: if (sd_stb && rx_last) state_nx = S_EVAL;
            S_EVAL: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0; idx_q <= '0; rtype_q <= RT_NONE; crc_en_q <= 1'b0; idx_en_q <= 1'b0;
            wcnt <= '0;
            resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0;
            evt_done <= 1'b0; evt_error <= 1'b0; err_timeout <= 1'b0;
            err_crc <= 1'b0; err_index <= 1'b0; err_endbit <= 1'b0;
        end else begin
            if (arg_we) arg_q <= arg_wdata;
            if (accept) begin
                idx_q <= w_idx; rtype_q <= w_rtype;
                crc_en_q <= w_crc_chk; idx_en_q <= w_idx_chk;
                wcnt <= '0;
            end else if (state == S_WAIT && sd_stb && cmd_in) begin
                wcnt <= wcnt + 1'b1;
            end
            if (state == S_EVAL && is_long) begin
                resp3 <= {8'h00, rx_sr[127:104]};
                resp2 <= rx_sr[103:72];
                resp1 <= rx_sr[71:40];
                resp0 <= rx_sr[39:8];
            end else if (state == S_EVAL && has_rsp) begin
                resp0 <= rx_sr[39:8];
            end
            evt_done    <= (state == S_EVAL);
            err_crc     <= (state == S_EVAL) && crc_bad;
            err_index   <= (state == S_EVAL) && idx_bad;
            err_endbit  <= (state == S_EVAL) && end_bad;
            err_timeout <= timeout_hit;
            evt_error   <= ((state == S_EVAL) && (crc_bad || idx_bad || end_bad)) || timeout_hit;
        end
    end

    assign inhibit_cmd = (state != S_IDLE);
    assign cmd_oe      = (state == S_SEND);
    assign cmd_out     = cmd_oe ? tx_bit : 1'b1;
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_oe,
    input logic cmd_out,
    input logic inhibit_cmd,
    input logic inhibit_dat,
    input logic evt_done,
    input logic evt_error,
    input logic err_timeout,
    input logic err_crc,
    input logic err_index,
    input logic err_endbit
);
    // R1
    frame_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    // R1
    drive_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> inhibit_cmd);
    // R3
    event_clears_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done || evt_error) |-> !inhibit_cmd);
    // R7
    crc_flag_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc |-> (evt_error && evt_done));
    // R8
    index_flag_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_index |-> evt_error);
    // R9
    endbit_flag_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_endbit |-> evt_error);
    // R10
    timeout_without_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (evt_error && !evt_done));
    // R11
    busy_rises_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inhibit_dat) |-> inhibit_cmd);
    // R12
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);
    // R12
    error_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_error |=> !evt_error);
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
    .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat),
    .evt_done(evt_done), .evt_error(evt_error), .err_timeout(err_timeout),
    .err_crc(err_crc), .err_index(err_index), .err_endbit(err_endbit)
);

// File: tb/sdc_cmd_engine_test.sv
module sdc_cmd_engine_test;
    logic clk = 1'b0, rst_n = 1'b0, sd_stb = 1'b1;
    logic arg_we = 1'b0, cmd_we = 1'b0, cmd_in = 1'b1, dat0_in = 1'b1;
    logic [31:0] arg_wdata = '0;
    logic [15:0] cmd_wdata = '0;
    logic cmd_out, cmd_oe, inhibit_cmd, inhibit_dat;
    logic [31:0] resp0, resp1, resp2, resp3;
    logic evt_done, evt_error, err_timeout, err_crc, err_index, err_endbit;
    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    sdc_cmd_engine uut (.*);

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  rt;
        logic        crc_en;
        logic        idx_en;
        logic [5:0]  ridx;
        logic        bad_crc;
        logic        e_crc;
        logic        e_idx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'd0,  32'h0000_0000, 2'b00, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0},
        '{6'd8,  32'h0000_01AA, 2'b10, 1'b1, 1'b1, 6'd8,  1'b0, 1'b0, 1'b0},
        '{6'd17, 32'h0000_1234, 2'b10, 1'b1, 1'b1, 6'd17, 1'b1, 1'b1, 1'b0},
        '{6'd13, 32'hDEAD_BEEF, 2'b10, 1'b0, 1'b1, 6'd12, 1'b0, 1'b0, 1'b1},
        '{6'd13, 32'h0F0F_00FF, 2'b10, 1'b0, 1'b0, 6'd12, 1'b0, 1'b0, 1'b0},
        '{6'd2,  32'h8765_4321, 2'b01, 1'b1, 1'b0, 6'd63, 1'b0, 1'b0, 1'b0},
        '{6'd9,  32'h1357_2468, 2'b01, 1'b1, 1'b0, 6'd63, 1'b1, 1'b1, 1'b0},
        '{6'd55, 32'hCAFE_F00D, 2'b10, 1'b0, 1'b0, 6'd55, 1'b1, 1'b0, 1'b0}
    };

    // CRC7 by polynomial long division
    function automatic logic [6:0] ref_crc(input logic [119:0] d);
        logic [126:0] v;
        v = {d, 7'b0};
        for (int i = 126; i >= 7; i--)
            if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'b1000_1001;
        return v[6:0];
    endfunction

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input logic crc_en, input logic idx_en);
        @(negedge clk); arg_we = 1'b1; arg_wdata = arg;
        @(negedge clk); arg_we = 1'b0; cmd_we = 1'b1;
        cmd_wdata = {2'b00, idx, 3'b000, idx_en, crc_en, 1'b0, rt};
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic capture(output logic [47:0] fr);
        fr = '1;
        for (int i = 0; i < 48 && cmd_oe === 1'b1; i++) begin
            fr[47 - i] = cmd_out;
            @(negedge clk);
        end
    endtask

    task automatic respond(input int gap, input logic [135:0] bits, input int len);
        for (int j = 0; j < gap; j++) begin cmd_in = 1'b1; @(negedge clk); end
        for (int i = len - 1; i >= 0; i--) begin cmd_in = bits[i]; @(negedge clk); end
        cmd_in = 1'b1;
    endtask

    logic got, p_done, p_err, p_to, p_crc, p_idx, p_end;
    task automatic poll(input int lim);
        got = 0; p_done = 0; p_err = 0; p_to = 0; p_crc = 0; p_idx = 0; p_end = 0;
        for (int i = 0; i < lim && !got; i++) begin
            if (evt_done || evt_error) begin
                got = 1; p_done = evt_done; p_err = evt_error; p_to = err_timeout;
                p_crc = err_crc; p_idx = err_index; p_end = err_endbit;
            end else @(negedge clk);
        end
    endtask

    function automatic logic [47:0] short_rsp(input logic [5:0] ridx, input logic [31:0] st, input logic bad);
        logic [6:0] c;
        c = ref_crc({80'b0, 2'b00, ridx, st}) ^ {6'b0, bad};
        return {2'b00, ridx, st, c, 1'b1};
    endfunction

    function automatic logic [119:0] long_pay(input logic [31:0] a);
        return {a[23:0], ~a, a ^ 32'h1357_9BDF, a ^ 32'hC0FF_EE00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [47:0]  fr;
        logic [119:0] pay;
        logic [135:0] lr;
        int           ones;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 inhibits", {inhibit_cmd, inhibit_dat}, 2'b00);
        chk("R13 line", {cmd_oe, cmd_out}, 2'b01);
        chk("R13 result regs", {resp3, resp2, resp1, resp0}, 128'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1 R2 R4 R5 R6 R7 R8
        foreach (VECS[k]) begin
            issue(VECS[k].idx, VECS[k].arg, VECS[k].rt, VECS[k].crc_en, VECS[k].idx_en);
            chk("R3 inhibit_cmd during frame", inhibit_cmd, 1'b1);
            capture(fr);
            chk("R1 frame", fr, {2'b01, VECS[k].idx, VECS[k].arg,
                ref_crc({80'b0, 2'b01, VECS[k].idx, VECS[k].arg}), 1'b1});
            if (k == 0) chk("R1 CMD0 literal", fr, 48'h4000_0000_0095);
            if (k == 1) chk("R1 CMD8 literal", fr, 48'h4800_0001_AA87);
            pay = long_pay(VECS[k].arg);
            if (VECS[k].rt == 2'b10)
                respond(2, 136'(short_rsp(VECS[k].ridx, VECS[k].arg ^ 32'hA5A5_0F0F, VECS[k].bad_crc)), 48);
            else if (VECS[k].rt == 2'b01) begin
                lr = {2'b00, 6'h3F, pay, ref_crc(pay) ^ {6'b0, VECS[k].bad_crc}, 1'b1};
                respond(1, lr, 136);
            end
            poll(20);
            chk("R4 R12 done without timeout", {got, p_done, p_to, p_end}, 4'b1100);
            chk("R7 crc flag", {p_crc, p_err & VECS[k].e_crc}, {VECS[k].e_crc, VECS[k].e_crc});
            chk("R8 index flag", p_idx, VECS[k].e_idx);
            chk("R12 summary", p_err, VECS[k].e_crc | VECS[k].e_idx);
            @(negedge clk);
            chk("R12 pulse ends", {evt_done, evt_error}, 2'b00);
            if (VECS[k].rt == 2'b10) chk("R5 resp0", resp0, VECS[k].arg ^ 32'hA5A5_0F0F);
            if (VECS[k].rt == 2'b01)
                chk("R6 long layout", {resp3, resp2, resp1, resp0}, {8'h00, pay});
        end

        // R9 end bit zero
        issue(6'd7, 32'h1111_2222, 2'b10, 1'b1, 1'b1);
        capture(fr);
        respond(0, 136'(short_rsp(6'd7, 32'h5, 1'b0) & ~48'h1), 48);
        poll(20);
        chk("R9 end bit error", {p_done, p_err, p_end, p_crc, p_idx}, 5'b11100);

        // R3 command write during a frame is dropped
        issue(6'd5, 32'hAAAA_5555, 2'b00, 1'b0, 1'b0);
        fork
            capture(fr);
            begin
                repeat (3) @(negedge clk);
                cmd_we = 1'b1; cmd_wdata = {2'b00, 6'd40, 8'h00};
                @(negedge clk); cmd_we = 1'b0;
            end
        join
        chk("R3 first frame intact", fr, {2'b01, 6'd5, 32'hAAAA_5555,
            ref_crc({80'b0, 2'b01, 6'd5, 32'hAAAA_5555}), 1'b1});
        poll(10);
        chk("R3 single done", {got, p_done}, 2'b11);
        ones = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cmd_oe || evt_done) ones++;
        end
        chk("R3 no second command", ones, 0);

        // R10 start bit on the 64th sample is accepted
        issue(6'd6, 32'h0000_0042, 2'b10, 1'b1, 1'b1);
        capture(fr);
        respond(63, 136'(short_rsp(6'd6, 32'h0BAD_CAFE, 1'b0)), 48);
        poll(20);
        chk("R10 late start accepted", {p_done, p_err}, 2'b10);
        chk("R10 late start status", resp0, 32'h0BAD_CAFE);

        // R10 R11 timeout on a busy command clears both inhibits
        dat0_in = 1'b0;
        issue(6'd38, 32'h0, 2'b11, 1'b1, 1'b1);
        chk("R11 busy raised", inhibit_dat, 1'b1);
        capture(fr);
        poll(100);
        chk("R10 timeout flags", {got, p_done, p_err, p_to}, 4'b1011);
        chk("R10 R11 inhibits cleared", {inhibit_cmd, inhibit_dat}, 2'b00);

        // R11 busy wait with DAT0 held low
        issue(6'd7, 32'h0000_0001, 2'b11, 1'b1, 1'b1);
        capture(fr);
        respond(0, 136'(short_rsp(6'd7, 32'h0000_0900, 1'b0)), 48);
        poll(20);
        chk("R11 done before release", {p_done, p_err}, 2'b10);
        @(negedge clk);
        chk("R11 held after done", {inhibit_cmd, inhibit_dat}, 2'b01);
        issue(6'd12, 32'h0, 2'b11, 1'b0, 1'b0);
        chk("R11 busy command dropped", {cmd_oe, inhibit_cmd}, 2'b00);
        issue(6'd13, 32'h0000_0003, 2'b10, 1'b1, 1'b1);
        chk("R11 other kind accepted", {cmd_oe, inhibit_dat}, 2'b11);
        capture(fr);
        respond(0, 136'(short_rsp(6'd13, 32'h0000_0777, 1'b0)), 48);
        poll(20);
        chk("R11 second command ok", {p_done, p_err, inhibit_dat}, 3'b101);
        dat0_in = 1'b1;
        @(negedge clk);
        chk("R11 released by DAT0", inhibit_dat, 1'b0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule